// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the fetch half of a simple Ethernet transmitter. It sits idle until transmission is enabled and the current buffer descriptor is flagged ready. It then accepts the descriptor, latching its buffer pointer and frame length, and reads the frame out of system memory one 32-bit word at a time. Each word is split into bytes, most significant byte first, and written into a local byte buffer that the transmit path reads by index.

Reads go through a simple request/valid port. The request and address are held until the memory returns data-valid. The address of each read is the latched pointer plus the number of bytes already fetched. That count grows by four per word. When the count reaches or passes the frame length, the engine raises its frame-ready output and holds it until the transmit path reports that it has finished. The engine then returns to waiting for the next descriptor.

Top module: `txfetch_engine`

## Requirements
- R1: While `tx_en` is low or `desc_ready` is low in the waiting state, no descriptor is accepted, `mem_req` stays low and `frame_ready` stays low.
- R2: Every read address equals the latched descriptor pointer plus the bytes fetched so far for that frame, so the k-th read (counting from 0) of a frame goes to pointer + 4k.
- R3: A word fetched for byte offset 4k is stored so that buffer byte 4k+0 holds data bits 31:24, 4k+1 holds bits 23:16, 4k+2 holds bits 15:8 and 4k+3 holds bits 7:0.
- R4: The fetched-byte count advances by four per accepted word, so a frame of L bytes takes exactly ceil(L/4) reads, and consecutive reads of a frame are 4 apart.
- R5: Once the fetched-byte count is at least the latched length, no further read is issued and `frame_ready` rises; a zero-length descriptor reaches `frame_ready` with no read at all.
- R6: Buffer bytes at index L or above, including the unused bytes of the last partial word, keep their previous contents.
- R7: Accepting a new descriptor (signalled by the one-cycle `desc_accept`) clears the fetched-byte count, so the first read of every frame goes to that frame's own pointer.
- R8: While `mem_req` is high and `mem_valid` is low, `mem_req` stays high and `mem_addr` is unchanged in the next cycle.
- R9: `frame_ready` stays high until `xmit_done` is seen, and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Transmission enable |
| desc_ready | input | 1 | Current descriptor holds a frame to send |
| desc_ptr | input | AW (32) | Buffer address of the frame in memory |
| desc_len | input | LW (7) | Frame length in bytes, at most BUF_BYTES |
| desc_accept | output | 1 | One-cycle pulse: descriptor taken, fetch begins |
| mem_req | output | 1 | Read request, held until mem_valid |
| mem_addr | output | AW (32) | Byte address of the requested word |
| mem_rdata | input | DW (32) | Returned read data |
| mem_valid | input | 1 | Read data valid, one cycle per word |
| frame_ready | output | 1 | Whole frame is in the byte buffer |
| xmit_done | input | 1 | Transmit path has finished with the buffer |
| rd_idx | input | IW (6) | Byte index read by the transmit path |
| rd_byte | output | 8 | Buffer byte at rd_idx |

## Verification
The checker watches the memory handshake on every cycle. It checks that an unanswered request keeps its address, that each answered read is followed by one four bytes higher, and that the first read after an accept targets the accepted pointer. It also checks that a read and a ready frame never coexist, that an accept happens only with enable and ready both high, and that a ready frame holds until released. Byte order in the buffer, the exact read count per length and the untouched bytes past the end of a partial last word depend on data values across a whole frame. Only the bench's frame scenarios, compared byte by byte against computed contents, can show those.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SEND  = 2'd2
  } txf_state_e;
endpackage

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 7,
  parameter int CW    = 8,
  parameter int LANES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          desc_ready,
  input  logic [AW-1:0] desc_ptr,
  input  logic [LW-1:0] desc_len,
  input  logic          mem_valid,
  input  logic          xmit_done,
  output logic          desc_accept,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          frame_ready,
  output logic          word_we,
  output logic [CW-1:0] word_base,
  output logic [LW-1:0] frame_len
);
  txf_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [LW-1:0] len_q, len_d;
  logic          all_fetched;

  assign all_fetched = (cnt_q >= CW'(len_q));

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    ptr_d       = ptr_q;
    len_d       = len_q;
    desc_accept = 1'b0;
    mem_req     = 1'b0;
    word_we     = 1'b0;
    unique case (state_q)
      ST_WAIT: begin
        if (tx_en && desc_ready) begin
          desc_accept = 1'b1;
          ptr_d       = desc_ptr;
          len_d       = desc_len;
          cnt_d       = '0;
          state_d     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (all_fetched) begin
          state_d = ST_SEND;
        end else begin
          mem_req = 1'b1;
          if (mem_valid) begin
            word_we = 1'b1;
            cnt_d   = cnt_q + CW'(LANES);
          end
        end
      end
      ST_SEND: begin
        if (xmit_done) state_d = ST_WAIT;
      end
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      ptr_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      len_q   <= len_d;
    end
  end

  assign mem_addr    = ptr_q + AW'(cnt_q);
  assign frame_ready = (state_q == ST_SEND);
  assign word_base   = cnt_q;
  assign frame_len   = len_q;
endmodule

// File: rtl/txf_unpack.sv
module txf_unpack #(
  parameter int DW        = 32,
  parameter int BUF_BYTES = 64,
  parameter int LW        = 7,
  parameter int CW        = 8,
  parameter int IW        = 6
) (
  input  logic          clk,
  input  logic          word_we,
  input  logic [CW-1:0] word_base,
  input  logic [LW-1:0] frame_len,
  input  logic [DW-1:0] word,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);
  localparam int LANES = DW / 8;

  logic [7:0]    store [BUF_BYTES];
  logic [LANES-1:0] lane_we;
  logic [IW-1:0] lane_idx  [LANES];
  logic [7:0]    lane_byte [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [CW-1:0] pos;
    assign pos          = word_base + CW'(j);
    assign lane_we[j]   = word_we && (pos < CW'(frame_len));
    assign lane_idx[j]  = pos[IW-1:0];
    assign lane_byte[j] = word[DW-1-8*j -: 8];
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < LANES; j++) begin
      if (lane_we[j]) store[lane_idx[j]] <= lane_byte[j];
    end
  end

  assign rd_byte = store[rd_idx];
endmodule

// File: rtl/txfetch_engine.sv
module txfetch_engine #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int BUF_BYTES = 64,
  localparam int LW       = $clog2(BUF_BYTES + 1),
  localparam int IW       = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          desc_ready,
  input  logic [AW-1:0] desc_ptr,
  input  logic [LW-1:0] desc_len,
  output logic          desc_accept,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_valid,
  output logic          frame_ready,
  input  logic          xmit_done,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);
  localparam int CW    = LW + 1;
  localparam int LANES = DW / 8;

  logic [1:0]    rst_sync_q;
  logic          srst_n;
  logic          word_we;
  logic [CW-1:0] word_base;
  logic [LW-1:0] frame_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  txf_ctrl #(.AW(AW), .LW(LW), .CW(CW), .LANES(LANES)) u_ctrl (
    .clk         (clk),
    .rst_n       (srst_n),
    .tx_en       (tx_en),
    .desc_ready  (desc_ready),
    .desc_ptr    (desc_ptr),
    .desc_len    (desc_len),
    .mem_valid   (mem_valid),
    .xmit_done   (xmit_done),
    .desc_accept (desc_accept),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .frame_ready (frame_ready),
    .word_we     (word_we),
    .word_base   (word_base),
    .frame_len   (frame_len)
  );

  txf_unpack #(.DW(DW), .BUF_BYTES(BUF_BYTES), .LW(LW), .CW(CW), .IW(IW)) u_unpack (
    .clk       (clk),
    .word_we   (word_we),
    .word_base (word_base),
    .frame_len (frame_len),
    .word      (mem_rdata),
    .rd_idx    (rd_idx),
    .rd_byte   (rd_byte)
  );
endmodule

// File: rtl/txf_chk.sv
module txf_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          desc_ready,
  input logic [AW-1:0] desc_ptr,
  input logic          desc_accept,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_valid,
  input logic          frame_ready,
  input logic          xmit_done
);
  // R1: accept only with enable and ready, from the quiet waiting state
  assert_accept_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    desc_accept |-> (tx_en && desc_ready && !mem_req && !frame_ready));

  // R7 and R2: first read after an accept targets the accepted pointer
  assert_first_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_accept |=> (!mem_req || (mem_addr == $past(desc_ptr))));

  // R8: an unanswered request holds
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R4: next read of the frame is four bytes higher
  assert_step_four_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (!mem_req || (mem_addr == $past(mem_addr) + AW'(4))));

  // R5: no read once the frame is complete
  assert_no_read_when_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && frame_ready));

  // R9: frame stays ready until released, then drops
  assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ready && !xmit_done) |=> frame_ready);
  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ready && xmit_done) |=> !frame_ready);
endmodule

bind txfetch_engine txf_chk #(.AW(AW)) u_txf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .desc_ready  (desc_ready),
  .desc_ptr    (desc_ptr),
  .desc_accept (desc_accept),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_valid   (mem_valid),
  .frame_ready (frame_ready),
  .xmit_done   (xmit_done)
);

// File: tb/txfetch_engine_tb.sv
module txfetch_engine_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NB = 64;
  localparam int LW = $clog2(NB + 1);
  localparam int IW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_en = 1'b0;
  logic          desc_ready = 1'b0;
  logic [AW-1:0] desc_ptr = '0;
  logic [LW-1:0] desc_len = '0;
  logic          desc_accept;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_valid = 1'b0;
  logic          frame_ready;
  logic          xmit_done = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [7:0]    rd_byte;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0]    shadow [NB];
  logic [31:0]   key = '0;
  logic [AW-1:0] exp_ptr = '0;
  int            words_seen = 0;
  int            lat_left = 0;

  always #5 clk = ~clk;

  txfetch_engine #(.AW(AW), .DW(DW), .BUF_BYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .desc_ready(desc_ready),
    .desc_ptr(desc_ptr), .desc_len(desc_len), .desc_accept(desc_accept),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid), .frame_ready(frame_ready), .xmit_done(xmit_done),
    .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

  function automatic logic [31:0] mem_word(input logic [AW-1:0] a, input logic [31:0] k);
    return (a * 32'h9E37_79B1) ^ k;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [AW-1:0] p, input int i, input logic [31:0] k);
    logic [31:0] w;
    w = mem_word(p + AW'((i / 4) * 4), k);
    return w[31 - 8 * (i % 4) -: 8];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: answers a held request after 0..2 idle cycles; R2/R8 address check at data time
  always @(negedge clk) begin
    mem_valid = 1'b0;
    if (rst_n && mem_req) begin
      if (lat_left == 0) begin
        check(mem_addr == exp_ptr + AW'(4 * words_seen), "R2", mem_addr, exp_ptr + AW'(4 * words_seen));
        mem_rdata  = mem_word(mem_addr, key);
        mem_valid  = 1'b1;
        words_seen = words_seen + 1;
        lat_left   = $urandom % 3;
      end else begin
        lat_left = lat_left - 1;
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_frame(input logic [AW-1:0] p, input int len, input logic [31:0] k);
    int n;
    @(negedge clk);
    key = k; exp_ptr = p; words_seen = 0; lat_left = $urandom % 3;
    desc_ptr = p; desc_len = LW'(len); tx_en = 1'b1; desc_ready = 1'b1;
    #1;
    check(desc_accept == 1'b1, "R7", desc_accept, 1);
    @(negedge clk);
    desc_ready = 1'b0;
    n = 0;
    while (!frame_ready && n < 600) begin
      @(negedge clk); #1; n++;
    end
    check(frame_ready == 1'b1, "R5", frame_ready, 1);
    check(words_seen == (len + 3) / 4, "R4", words_seen, (len + 3) / 4);
    for (int i = 0; i < NB; i++) begin
      logic [7:0] e;
      rd_idx = IW'(i);
      #1;
      e = (i < len) ? exp_byte(p, i, k) : shadow[i];
      if (i < len) check(rd_byte == e, "R3", rd_byte, e);
      else         check(rd_byte == e, "R6", rd_byte, e);
      shadow[i] = e;
    end
    // R9: hold while not released
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      check(frame_ready == 1'b1 && mem_req == 1'b0, "R9", frame_ready, 1);
    end
    @(negedge clk);
    xmit_done = 1'b1;
    @(negedge clk);
    xmit_done = 1'b0;
    #1;
    check(frame_ready == 1'b0, "R9", frame_ready, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NB; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(mem_req == 1'b0 && frame_ready == 1'b0 && desc_accept == 1'b0, "reset", {mem_req, frame_ready}, 0);

    // R1: enabled but descriptor not ready, then ready but not enabled
    @(negedge clk); tx_en = 1'b1; desc_ready = 1'b0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); #1;
      check(!mem_req && !desc_accept && !frame_ready, "R1", {mem_req, desc_accept, frame_ready}, 0);
    end
    @(negedge clk); tx_en = 1'b0; desc_ready = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); #1;
      check(!mem_req && !desc_accept && !frame_ready, "R1", {mem_req, desc_accept, frame_ready}, 0);
    end
    desc_ready = 1'b0;

    // Directed corner cases: full buffer, partial last word over old data, zero length
    run_frame(32'h0000_1000, NB, 32'hA5A5_0001);
    run_frame(32'h0000_2001, 5, 32'h1234_5678);   // R6: bytes 5..7 keep old contents
    run_frame(32'h0000_3000, 0, 32'h0);           // R5: no read at all
    run_frame(32'h0000_4000, 1, 32'hDEAD_BEEF);
    run_frame(32'h0000_5000, 4, 32'hCAFE_F00D);

    // Constrained random frames; R7: each starts from its own pointer
    for (int f = 0; f < 40; f++) begin
      run_frame($urandom, $urandom % (NB + 1), $urandom);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule